// File: doc/BRIEF.md
# First-Touch Page Placement Table

This block decides, in hardware, which memory partition owns each virtual page of a multi-module processor. Every compute module has its own request port carrying a page number and an in-page byte offset. The first reference to a page binds that page to the partition local to the module that made it. The binding is stored in a fully associative table. Every later reference returns the stored partition, whichever module makes it.

Bindings remain in place until the table is cleared. A kernel boundary does not flush them. Each response also carries a channel index inside the chosen partition. The index comes from the offset bits just above the line offset, so consecutive lines are spread over the partition's channels.

Each port uses a valid/ready handshake. An accepted request is answered one cycle later. When the table is full, a page that is not yet bound is refused with an overflow flag, and no existing entry is replaced. A clear input drops every binding in a single cycle.

Top module: `first_touch_map`

## Requirements
- R1: A request for an unbound page that is accepted and granted a slot returns resp_first=1, resp_overflow=0 and a partition equal to the requesting port's index. From then on the page is bound to that partition.
- R2: A request for a bound page, from any port and at any later time, returns resp_first=0, resp_overflow=0 and the bound partition. A bound entry never changes and never disappears unless the table is cleared.
- R3: When several ports present the same unbound page in one cycle, the lowest-numbered of them binds it. The other ports receive that port's partition with resp_first=0, or an overflow if the binding failed.
- R4: resp_chan equals (offset / 2^LINE_LOG2) mod NUM_CH, with LINE_LOG2=7 (128-byte lines). It does not depend on the partition or on the hit/miss outcome.
- R5: With all CAPACITY entries in use, a request for an unbound page returns resp_overflow=1, resp_first=0 and partition 0. It evicts nothing and adds nothing, and every existing binding still hits afterwards.
- R6: Distinct unbound pages presented in the same cycle take free slots in ascending port order. The ports that find no slot left receive overflow.
- R7: While clear is high, every req_ready is 0. After the clock edge at which clear is high, the table is empty, so the next reference to any page is a first touch again.
- R8: resp_valid[i] is 1 in exactly the cycle after the edge at which req_valid[i] and req_ready[i] were both 1, and 0 otherwise.
- R9: After reset the table is empty, no response is valid, and all ports are ready when clear is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Drop all bindings at this edge |
| req_valid | input | NUM_MODS | Request present, one bit per module port |
| req_ready | output | NUM_MODS | Request can be taken this cycle |
| req_page | input | NUM_MODS*PAGE_W | Virtual page number per port |
| req_offset | input | NUM_MODS*OFF_W | Byte offset inside the page per port |
| resp_valid | output | NUM_MODS | Response present, per port |
| resp_first | output | NUM_MODS | This request created the binding |
| resp_overflow | output | NUM_MODS | Page unbound and table full |
| resp_part | output | NUM_MODS*PART_W | Owning memory partition per port |
| resp_chan | output | NUM_MODS*CH_W | Channel within the partition per port |

## Verification
The assertions assume that reset is released away from a clock edge, that the page and offset inputs are known whenever the matching valid bit is high, and that clear is a plain synchronous pulse. The bench drives every input at the falling edge and releases reset there. It holds valids high during clear cycles on purpose, to show that nothing is accepted. Random traffic draws pages from a range twice the table capacity, so same-cycle duplicates, a full table and overflows all occur often, and the table is cleared at intervals.

// File: rtl/ftp_pkg.sv
package ftp_pkg;

  // channel inside a partition: line index modulo channel count
  function automatic int chan_index(input int offset, input int line_log2, input int nch);
    return (offset >> line_log2) % nch;
  endfunction

  // number of set bits below position lim in a small vector
  function automatic int ones_below(input logic [31:0] v, input int lim);
    int n;
    n = 0;
    for (int k = 0; k < 32; k++) begin
      if (k < lim && v[k]) n++;
    end
    return n;
  endfunction

endpackage

// File: rtl/ftp_lookup.sv
module ftp_lookup #(
  parameter int NUM_MODS = 4,
  parameter int CAPACITY = 8,
  parameter int PAGE_W   = 16,
  parameter int PART_W   = 2
) (
  input  logic [CAPACITY-1:0]          tbl_valid,
  input  logic [CAPACITY*PAGE_W-1:0]   tbl_page,
  input  logic [CAPACITY*PART_W-1:0]   tbl_part,
  input  logic [NUM_MODS*PAGE_W-1:0]   look_page,
  output logic [NUM_MODS-1:0]          hit,
  output logic [NUM_MODS*PART_W-1:0]   hit_part
);

  for (genvar i = 0; i < NUM_MODS; i++) begin : g_port
    always_comb begin
      hit[i] = 1'b0;
      hit_part[i*PART_W +: PART_W] = '0;
      for (int e = 0; e < CAPACITY; e++) begin
        if (tbl_valid[e] && tbl_page[e*PAGE_W +: PAGE_W] == look_page[i*PAGE_W +: PAGE_W]) begin
          hit[i] = 1'b1;
          hit_part[i*PART_W +: PART_W] = tbl_part[e*PART_W +: PART_W];
        end
      end
    end
  end

endmodule

// File: rtl/ftp_resolve.sv
module ftp_resolve #(
  parameter int NUM_MODS = 4,
  parameter int PAGE_W   = 16,
  parameter int PART_W   = 2
) (
  input  logic [NUM_MODS-1:0]        miss,
  input  logic [NUM_MODS*PAGE_W-1:0] page,
  output logic [NUM_MODS-1:0]        leader,
  output logic [NUM_MODS*PART_W-1:0] owner,
  output logic [NUM_MODS*PART_W-1:0] rank
);

  for (genvar i = 0; i < NUM_MODS; i++) begin : g_port
    always_comb begin
      logic found;
      found = 1'b0;
      owner[i*PART_W +: PART_W] = PART_W'(i);
      for (int j = 0; j < i; j++) begin
        if (!found && miss[j] && page[j*PAGE_W +: PAGE_W] == page[i*PAGE_W +: PAGE_W]) begin
          found = 1'b1;
          owner[i*PART_W +: PART_W] = PART_W'(j);
        end
      end
      leader[i] = miss[i] && !found;
    end
    assign rank[i*PART_W +: PART_W] = PART_W'(ftp_pkg::ones_below(32'(leader), i));
  end

endmodule

// File: rtl/ftp_slot_pick.sv
module ftp_slot_pick #(
  parameter int NUM_MODS = 4,
  parameter int CAPACITY = 8,
  parameter int IDX_W    = 3,
  parameter int PART_W   = 2
) (
  input  logic [CAPACITY-1:0]        free,
  input  logic [NUM_MODS*PART_W-1:0] rank,
  output logic [NUM_MODS*IDX_W-1:0]  slot,
  output logic [NUM_MODS-1:0]        found
);

  for (genvar i = 0; i < NUM_MODS; i++) begin : g_port
    always_comb begin
      int cnt;
      cnt = 0;
      found[i] = 1'b0;
      slot[i*IDX_W +: IDX_W] = '0;
      for (int e = 0; e < CAPACITY; e++) begin
        if (free[e] && !found[i]) begin
          if (cnt == int'(rank[i*PART_W +: PART_W])) begin
            found[i] = 1'b1;
            slot[i*IDX_W +: IDX_W] = IDX_W'(e);
          end else begin
            cnt++;
          end
        end
      end
    end
  end

endmodule

// File: rtl/first_touch_map.sv
module first_touch_map #(
  parameter int NUM_MODS  = 4,
  parameter int CAPACITY  = 8,
  parameter int PAGE_W    = 16,
  parameter int OFF_W     = 12,
  parameter int NUM_CH    = 4,
  parameter int LINE_LOG2 = 7,
  localparam int PART_W   = (NUM_MODS > 1) ? $clog2(NUM_MODS) : 1,
  localparam int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clear,
  input  logic [NUM_MODS-1:0]         req_valid,
  output logic [NUM_MODS-1:0]         req_ready,
  input  logic [NUM_MODS*PAGE_W-1:0]  req_page,
  input  logic [NUM_MODS*OFF_W-1:0]   req_offset,
  output logic [NUM_MODS-1:0]         resp_valid,
  output logic [NUM_MODS-1:0]         resp_first,
  output logic [NUM_MODS-1:0]         resp_overflow,
  output logic [NUM_MODS*PART_W-1:0]  resp_part,
  output logic [NUM_MODS*CH_W-1:0]    resp_chan
);

  localparam int IDX_W = (CAPACITY > 1) ? $clog2(CAPACITY) : 1;

  // binding table
  logic [CAPACITY-1:0]        tbl_valid_q;
  logic [CAPACITY*PAGE_W-1:0] tbl_page_q;
  logic [CAPACITY*PART_W-1:0] tbl_part_q;

  // internal events, named for the assertions
  logic [NUM_MODS-1:0]        accept;
  logic [NUM_MODS-1:0]        hit;
  logic [NUM_MODS*PART_W-1:0] hit_part;
  logic [NUM_MODS-1:0]        miss;
  logic [NUM_MODS-1:0]        leader;
  logic [NUM_MODS*PART_W-1:0] owner;
  logic [NUM_MODS*PART_W-1:0] rank;
  logic [NUM_MODS*IDX_W-1:0]  slot;
  logic [NUM_MODS-1:0]        found;
  logic [NUM_MODS-1:0]        alloc_evt;
  logic [NUM_MODS-1:0]        ovf_evt;

  // next response values
  logic [NUM_MODS-1:0]        first_d;
  logic [NUM_MODS-1:0]        ovf_d;
  logic [NUM_MODS*PART_W-1:0] part_d;
  logic [NUM_MODS*CH_W-1:0]   chan_d;

  assign req_ready = {NUM_MODS{~clear}};
  assign accept    = req_valid & req_ready;
  assign miss      = accept & ~hit;

  ftp_lookup #(
    .NUM_MODS(NUM_MODS), .CAPACITY(CAPACITY), .PAGE_W(PAGE_W), .PART_W(PART_W)
  ) lookup_i (
    .tbl_valid(tbl_valid_q), .tbl_page(tbl_page_q), .tbl_part(tbl_part_q),
    .look_page(req_page), .hit(hit), .hit_part(hit_part)
  );

  ftp_resolve #(
    .NUM_MODS(NUM_MODS), .PAGE_W(PAGE_W), .PART_W(PART_W)
  ) resolve_i (
    .miss(miss), .page(req_page), .leader(leader), .owner(owner), .rank(rank)
  );

  ftp_slot_pick #(
    .NUM_MODS(NUM_MODS), .CAPACITY(CAPACITY), .IDX_W(IDX_W), .PART_W(PART_W)
  ) pick_i (
    .free(~tbl_valid_q), .rank(rank), .slot(slot), .found(found)
  );

  assign alloc_evt = leader & found;
  assign ovf_evt   = leader & ~found;

  always_comb begin
    for (int i = 0; i < NUM_MODS; i++) begin
      logic [PART_W-1:0] o;
      o = owner[i*PART_W +: PART_W];
      first_d[i] = 1'b0;
      ovf_d[i]   = 1'b0;
      part_d[i*PART_W +: PART_W] = '0;
      if (accept[i] && hit[i]) begin
        part_d[i*PART_W +: PART_W] = hit_part[i*PART_W +: PART_W];
      end else if (leader[i]) begin
        if (found[i]) begin
          first_d[i] = 1'b1;
          part_d[i*PART_W +: PART_W] = PART_W'(i);
        end else begin
          ovf_d[i] = 1'b1;
        end
      end else if (miss[i]) begin
        if (found[o]) part_d[i*PART_W +: PART_W] = o;
        else          ovf_d[i] = 1'b1;
      end
      chan_d[i*CH_W +: CH_W] =
        CH_W'(ftp_pkg::chan_index(int'(req_offset[i*OFF_W +: OFF_W]), LINE_LOG2, NUM_CH));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbl_valid_q   <= '0;
      tbl_page_q    <= '0;
      tbl_part_q    <= '0;
      resp_valid    <= '0;
      resp_first    <= '0;
      resp_overflow <= '0;
      resp_part     <= '0;
      resp_chan     <= '0;
    end else if (clear) begin
      tbl_valid_q   <= '0;
      resp_valid    <= '0;
      resp_first    <= '0;
      resp_overflow <= '0;
    end else begin
      for (int i = 0; i < NUM_MODS; i++) begin
        if (alloc_evt[i]) begin
          tbl_valid_q[slot[i*IDX_W +: IDX_W]] <= 1'b1;
          tbl_page_q[slot[i*IDX_W +: IDX_W]*PAGE_W +: PAGE_W] <= req_page[i*PAGE_W +: PAGE_W];
          tbl_part_q[slot[i*IDX_W +: IDX_W]*PART_W +: PART_W] <= PART_W'(i);
        end
      end
      resp_valid    <= accept;
      resp_first    <= first_d;
      resp_overflow <= ovf_d;
      resp_part     <= part_d;
      resp_chan     <= chan_d;
    end
  end

  // ---------------- assertions ----------------
  for (genvar i = 0; i < NUM_MODS; i++) begin : g_port_chk
    assert_first_local_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid[i] && resp_first[i]) |-> resp_part[i*PART_W +: PART_W] == PART_W'(i));

    assert_accept_resp_R8: assert property (@(posedge clk) disable iff (!rst_n)
      accept[i] |=> resp_valid[i]);

    assert_idle_resp_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !accept[i] |=> !resp_valid[i]);

    assert_lead_owner_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (miss[i] && !leader[i]) |-> owner[i*PART_W +: PART_W] < PART_W'(i));
  end

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt != '0) |=> $countones(tbl_valid_q) == CAPACITY);

  assert_clear_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (tbl_valid_q == '0 && resp_valid == '0));

  for (genvar e = 0; e < CAPACITY; e++) begin : g_entry_chk
    assert_bind_persist_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tbl_valid_q[e] && !clear) |=> (tbl_valid_q[e] &&
        $stable(tbl_page_q[e*PAGE_W +: PAGE_W]) && $stable(tbl_part_q[e*PART_W +: PART_W])));
    for (genvar f = e + 1; f < CAPACITY; f++) begin : g_pair
      assert_unique_page_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_valid_q[e] && tbl_valid_q[f]) |->
          tbl_page_q[e*PAGE_W +: PAGE_W] != tbl_page_q[f*PAGE_W +: PAGE_W]);
    end
  end

endmodule

// File: tb/first_touch_map_tb_top.sv
`timescale 1ns/1ps
module first_touch_map_tb_top;

  localparam int NM     = 4;
  localparam int CAP    = 8;
  localparam int PAGE_W = 16;
  localparam int OFF_W  = 12;
  localparam int NCH    = 4;
  localparam int PART_W = 2;
  localparam int CH_W   = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clear = 1'b0;
  logic [NM-1:0]        req_valid = '0;
  logic [NM-1:0]        req_ready;
  logic [NM*PAGE_W-1:0] req_page = '0;
  logic [NM*OFF_W-1:0]  req_offset = '0;
  logic [NM-1:0]        resp_valid, resp_first, resp_overflow;
  logic [NM*PART_W-1:0] resp_part;
  logic [NM*CH_W-1:0]   resp_chan;

  always #2 clk = ~clk;

  first_touch_map dut_i (
    .clk(clk), .rst_n(rst_n), .clear(clear),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_page(req_page), .req_offset(req_offset),
    .resp_valid(resp_valid), .resp_first(resp_first), .resp_overflow(resp_overflow),
    .resp_part(resp_part), .resp_chan(resp_chan)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  // reference model of the bindings
  int m_cnt = 0;
  int m_page [CAP];
  int m_part [CAP];

  // per-cycle drive values
  bit drv_v   [NM];
  int drv_pg  [NM];
  int drv_off [NM];
  bit drv_clr;

  task automatic chk(input string tag, input string what, input int port, input int got, input int exp);
    n_vec++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s port %0d %s: got %0d expected %0d", tag, port, what, got, exp);
    end
  endtask

  function automatic int m_find(input int pg);
    for (int k = 0; k < m_cnt; k++) if (m_page[k] == pg) return k;
    return -1;
  endfunction

  task automatic idle_drv();
    for (int i = 0; i < NM; i++) begin drv_v[i] = 0; drv_pg[i] = 0; drv_off[i] = 0; end
    drv_clr = 0;
  endtask

  // drive at a falling edge, check at the next falling edge
  task automatic run_cycle(input string tag);
    bit e_v [NM]; bit e_f [NM]; bit e_o [NM]; int e_p [NM]; int e_c [NM];
    clear = drv_clr;
    for (int i = 0; i < NM; i++) begin
      req_valid[i] = drv_v[i];
      req_page[i*PAGE_W +: PAGE_W] = drv_pg[i][PAGE_W-1:0];
      req_offset[i*OFF_W +: OFF_W] = drv_off[i][OFF_W-1:0];
    end
    #0.1;
    for (int i = 0; i < NM; i++) chk(drv_clr ? "R7" : "R9", "ready", i, int'(req_ready[i]), drv_clr ? 0 : 1);
    if (drv_clr) m_cnt = 0;
    for (int i = 0; i < NM; i++) begin
      int k;
      e_v[i] = drv_v[i] && !drv_clr; e_f[i] = 0; e_o[i] = 0; e_p[i] = 0;
      e_c[i] = (drv_off[i] / 128) % NCH;
      if (e_v[i]) begin
        k = m_find(drv_pg[i]);
        if (k >= 0) e_p[i] = m_part[k];
        else if (m_cnt < CAP) begin
          m_page[m_cnt] = drv_pg[i]; m_part[m_cnt] = i; m_cnt++;
          e_f[i] = 1; e_p[i] = i;
        end else e_o[i] = 1;
      end
    end
    @(negedge clk);
    for (int i = 0; i < NM; i++) begin
      chk({tag, "/R8"}, "valid", i, int'(resp_valid[i]), int'(e_v[i]));
      if (e_v[i] && resp_valid[i]) begin
        chk({tag, e_o[i] ? "/R5" : (e_f[i] ? "/R1" : "/R2")}, "part", i,
            int'(resp_part[i*PART_W +: PART_W]), e_p[i]);
        chk({tag, "/R1"}, "first", i, int'(resp_first[i]), int'(e_f[i]));
        chk({tag, "/R5"}, "overflow", i, int'(resp_overflow[i]), int'(e_o[i]));
        chk({tag, "/R4"}, "chan", i, int'(resp_chan[i*CH_W +: CH_W]), e_c[i]);
      end
    end
  endtask

  task automatic one(input string tag, input int port, input int pg, input int off);
    idle_drv();
    drv_v[port] = 1; drv_pg[port] = pg; drv_off[port] = off;
    run_cycle(tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    idle_drv();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state
    for (int i = 0; i < NM; i++) begin
      chk("R9", "valid", i, int'(resp_valid[i]), 0);
      chk("R9", "ready", i, int'(req_ready[i]), 1);
    end

    // R1 / R4: each port first-touches its own page, offset sweep over lines
    for (int m = 0; m < NM; m++)
      for (int k = 0; k < 8; k++) one("R1", m, 10 + m, k * 128 + k * 3);

    // R2: every port references every bound page
    for (int m = 0; m < NM; m++)
      for (int p = 0; p < NM; p++) one("R2", m, 10 + p, p * 640 + 5);

    // R3: all ports touch one new page together
    idle_drv();
    for (int i = 0; i < NM; i++) begin drv_v[i] = 1; drv_pg[i] = 20; drv_off[i] = i * 128; end
    run_cycle("R3");
    one("R3", 3, 20, 0);

    // R6: four distinct new pages, three free slots
    idle_drv();
    for (int i = 0; i < NM; i++) begin drv_v[i] = 1; drv_pg[i] = 30 + i; drv_off[i] = 4095 - i * 128; end
    run_cycle("R6");

    // R5: full table refuses new pages and keeps the old ones
    one("R5", 1, 40, 256);
    one("R5", 3, 33, 384);
    for (int p = 0; p < NM; p++) one("R5", (p + 1) % NM, 10 + p, 128);
    one("R5", 0, 20, 0);
    for (int p = 0; p < 3; p++) one("R5", 3 - p, 30 + p, 512);

    // R7: clear with valids held high, then first touch again
    idle_drv();
    drv_clr = 1;
    for (int i = 0; i < NM; i++) begin drv_v[i] = 1; drv_pg[i] = 10 + i; end
    run_cycle("R7");
    one("R7", 3, 10, 700);
    one("R7", 0, 10, 900);

    // random traffic with duplicates, full table and periodic clears
    for (int n = 0; n < 4000; n++) begin
      idle_drv();
      drv_clr = ($urandom_range(63) == 0);
      for (int i = 0; i < NM; i++) begin
        drv_v[i]   = ($urandom_range(3) != 0);
        drv_pg[i]  = $urandom_range(2 * CAP - 1);
        drv_off[i] = $urandom_range(4095);
      end
      run_cycle("RND");
    end

    idle_drv();
    run_cycle("END");
    finish_run();
  end

endmodule